// File: doc/BRIEF.md
# Prescaled Trigger Item Decision Unit

This block turns a vector of trigger object bits into a Level-1 accept decision. It holds a set of run-time programmable trigger items. Each item's condition is a sum of up to four product terms over the object vector. Each term lists the objects that must be set and the objects that must be clear, which lets an item express AND, OR and NOT combinations of objects. On top of its condition, each item carries an enable bit, a prescale factor and a priority class.

On every bunch-crossing strobe, the unit evaluates all items and advances the prescale divider of each enabled item whose condition holds. It then forms the accept as the OR of the items that survive prescaling. A general veto suppresses the accept, and so does a deadtime window. After each accept the deadtime window blocks a programmed number of later crossings. Two window lengths are programmed: a shorter one used when a high-priority item took part in the accept, and a longer one otherwise. Together with the one-cycle accept pulse, the unit latches and presents which items passed and whether any of them was high priority. All programming goes through a simple single-cycle write port.

Top module: `trig_decide`

## Requirements
- R1: After reset the accept output, the per-item result vector and the priority output are zero. All term masks, enables and windows are cleared, so no crossing produces an accept until the unit is programmed.
- R2: A product term is true when every object in its required-set mask is 1 and every object in its required-clear mask is 0. A term whose two masks are both zero is inactive and never true.
- R3: An item's raw condition is the OR of its product terms.
- R4: An item whose enable bit (control word bit 0) is 0 never passes and its prescale counter does not advance.
- R5: With prescale factor N (control word bits 2 and up; N of 0 or 1 means every firing passes), an enabled item passes on every Nth crossing on which its raw condition is true, counted from the last write of its control word.
- R6: The accept is a one-cycle pulse in the clock cycle after a crossing strobe on which at least one item passed and the veto was low.
- R7: After an accept, the next W crossings cannot accept. W is the high-priority window (global word bits 15:8) if any passing item had its priority bit (control word bit 1) set, and the low-priority window (bits 7:0) otherwise. Prescale counters keep advancing during the window.
- R8: The per-item result vector and priority output are updated only together with an accept and hold their values otherwise.
- R9: Cycles without a crossing strobe change no output and advance no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bx_i | input | 1 | Bunch-crossing strobe, one cycle per crossing |
| obj_i | input | N_OBJ | Trigger object bits for this crossing |
| veto_i | input | 1 | General veto, sampled with the strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_item_i | input | IW | Target item index |
| cfg_sel_i | input | SW | Field select: 0..N_TERM-1 set masks, N_TERM..2*N_TERM-1 clear masks, 2*N_TERM control word, 2*N_TERM+1 global deadtime word |
| cfg_data_i | input | DW | Write data |
| l1a_o | output | 1 | Accept pulse |
| item_o | output | N_ITEM | Items that passed in the last accept |
| prio_o | output | 1 | A high-priority item passed in the last accept |

## Verification
All three results come from one register stage, so they are due in the cycle after the strobe. The bench drives a crossing on a falling edge, drops the strobe on the next falling edge, and samples the outputs there, one edge after the capturing rising edge. A further idle cycle is then sampled to confirm that the accept has fallen and the latched vectors hold. A configuration write takes effect at the rising edge of its own cycle, so it applies to every later crossing.

// File: rtl/trig_decide.sv
module trig_decide #(
  parameter int N_OBJ  = 16,
  parameter int N_ITEM = 12,
  parameter int N_TERM = 4,
  parameter int PS_W   = 10,
  parameter int DT_W   = 8,
  localparam int IW    = $clog2(N_ITEM),
  localparam int SW    = $clog2(2*N_TERM+2),
  localparam int DW0   = (N_OBJ > 2+PS_W) ? N_OBJ : 2+PS_W,
  localparam int DW    = (DW0 > 2*DT_W) ? DW0 : 2*DT_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bx_i,
  input  logic [N_OBJ-1:0]  obj_i,
  input  logic              veto_i,
  input  logic              cfg_we_i,
  input  logic [IW-1:0]     cfg_item_i,
  input  logic [SW-1:0]     cfg_sel_i,
  input  logic [DW-1:0]     cfg_data_i,
  output logic              l1a_o,
  output logic [N_ITEM-1:0] item_o,
  output logic              prio_o
);
  localparam int SEL_CTL = 2*N_TERM;
  localparam int SEL_DT  = 2*N_TERM+1;

  logic [N_OBJ-1:0]  set_m [N_ITEM][N_TERM];
  logic [N_OBJ-1:0]  clr_m [N_ITEM][N_TERM];
  logic [PS_W-1:0]   ps_q  [N_ITEM];
  logic [PS_W-1:0]   cnt_q [N_ITEM];
  logic [N_ITEM-1:0] en_q, pri_q, raw, pass;
  logic [DT_W-1:0]   win_lo, win_hi, dead_q;
  logic              acc, hp;

  always_comb begin
    for (int i = 0; i < N_ITEM; i++) begin
      raw[i] = 1'b0;
      for (int t = 0; t < N_TERM; t++)
        raw[i] = raw[i] | ((|(set_m[i][t] | clr_m[i][t])) &
                           (&(obj_i | ~set_m[i][t])) &
                           ~(|(obj_i & clr_m[i][t])));
      pass[i] = en_q[i] & raw[i] &
                ((ps_q[i] <= PS_W'(1)) || (cnt_q[i] == ps_q[i] - PS_W'(1)));
    end
  end

  assign hp  = |(pass & pri_q);
  assign acc = bx_i & (|pass) & ~veto_i & (dead_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < N_ITEM; i++) begin
        for (int t = 0; t < N_TERM; t++) begin
          set_m[i][t] <= '0;
          clr_m[i][t] <= '0;
        end
        ps_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
      en_q   <= '0;
      pri_q  <= '0;
      win_lo <= '0;
      win_hi <= '0;
    end else begin
      for (int i = 0; i < N_ITEM; i++) begin
        if (cfg_we_i && cfg_item_i == IW'(i)) begin
          for (int t = 0; t < N_TERM; t++) begin
            if (cfg_sel_i == SW'(t))        set_m[i][t] <= cfg_data_i[N_OBJ-1:0];
            if (cfg_sel_i == SW'(N_TERM+t)) clr_m[i][t] <= cfg_data_i[N_OBJ-1:0];
          end
        end
        if (cfg_we_i && cfg_item_i == IW'(i) && cfg_sel_i == SW'(SEL_CTL)) begin
          en_q[i]  <= cfg_data_i[0];
          pri_q[i] <= cfg_data_i[1];
          ps_q[i]  <= cfg_data_i[2 +: PS_W];
          cnt_q[i] <= '0;
        end else if (bx_i && en_q[i] && raw[i]) begin
          cnt_q[i] <= pass[i] ? '0 : cnt_q[i] + PS_W'(1);
        end
      end
      if (cfg_we_i && cfg_sel_i == SW'(SEL_DT)) begin
        win_lo <= cfg_data_i[DT_W-1:0];
        win_hi <= cfg_data_i[DT_W +: DT_W];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dead_q <= '0;
      l1a_o  <= 1'b0;
      item_o <= '0;
      prio_o <= 1'b0;
    end else begin
      l1a_o <= acc;
      if (acc) begin
        item_o <= pass;
        prio_o <= hp;
        dead_q <= hp ? win_hi : win_lo;
      end else if (bx_i && dead_q != '0) begin
        dead_q <= dead_q - DT_W'(1);
      end
    end
  end

  assert_strobe_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    l1a_o |-> $past(bx_i));
  assert_veto_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    l1a_o |-> !$past(veto_i));
  assert_dead_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (bx_i && dead_q != '0) |=> !l1a_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !l1a_o |-> ($stable(item_o) && $stable(prio_o)));
  assert_nonempty_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    l1a_o |-> (item_o != '0));
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !bx_i |=> (!l1a_o && $stable(dead_q)));
endmodule

// File: tb/trig_decide_bench.sv
module trig_decide_bench;
  localparam int NO = 16, NI = 12, NT = 4, PSW = 10, DTW = 8;
  localparam int IW = $clog2(NI), SW = $clog2(2*NT+2);
  localparam int DW0 = (NO > 2+PSW) ? NO : 2+PSW;
  localparam int DW = (DW0 > 2*DTW) ? DW0 : 2*DTW;

  logic clk = 0, rst = 1, bx = 0, veto = 0, we = 0;
  logic [NO-1:0] obj = '0;
  logic [IW-1:0] citem = '0;
  logic [SW-1:0] csel = '0;
  logic [DW-1:0] cdata = '0;
  logic l1a, prio;
  logic [NI-1:0] items;

  trig_decide u_trig_decide (
    .clk_i(clk), .rst_i(rst), .bx_i(bx), .obj_i(obj), .veto_i(veto),
    .cfg_we_i(we), .cfg_item_i(citem), .cfg_sel_i(csel), .cfg_data_i(cdata),
    .l1a_o(l1a), .item_o(items), .prio_o(prio));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  logic [NO-1:0] m_set [NI][NT];
  logic [NO-1:0] m_clr [NI][NT];
  bit m_en [NI];
  bit m_pr [NI];
  int m_ps [NI];
  int m_cnt [NI];
  int m_lo = 0, m_hi = 0, m_dead = 0;
  bit e_l1a = 0, e_prio = 0;
  logic [NI-1:0] e_items = '0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic bit raw_of(int i, logic [NO-1:0] o);
    bit r = 0;
    for (int t = 0; t < NT; t++)
      if ((m_set[i][t] | m_clr[i][t]) != 0 &&
          (o & m_set[i][t]) == m_set[i][t] && (o & m_clr[i][t]) == 0)
        r = 1;
    return r;
  endfunction

  task automatic cfg(int it, int sel, logic [DW-1:0] d);
    @(negedge clk);
    we = 1; citem = IW'(it); csel = SW'(sel); cdata = d;
    if (sel < NT) m_set[it][sel] = d[NO-1:0];
    else if (sel < 2*NT) m_clr[it][sel-NT] = d[NO-1:0];
    else if (sel == 2*NT) begin
      m_en[it] = d[0]; m_pr[it] = d[1]; m_ps[it] = int'(d[2 +: PSW]); m_cnt[it] = 0;
    end else begin
      m_lo = int'(d[7:0]); m_hi = int'(d[15:8]);
    end
    @(negedge clk);
    we = 0;
  endtask

  task automatic ctl(int it, bit en, bit pr, int ps);
    logic [DW-1:0] d = '0;
    d[0] = en; d[1] = pr; d[2 +: PSW] = PSW'(ps);
    cfg(it, 2*NT, d);
  endtask

  task automatic xing(logic [NO-1:0] o, bit v, string tag);
    logic [NI-1:0] p = '0;
    bit hp = 0, acc;
    @(negedge clk);
    bx = 1; obj = o; veto = v;
    for (int i = 0; i < NI; i++) begin
      if (m_en[i] && raw_of(i, o)) begin
        if (m_ps[i] <= 1 || m_cnt[i] == m_ps[i]-1) begin
          p[i] = 1; m_cnt[i] = 0;
          if (m_pr[i]) hp = 1;
        end else m_cnt[i]++;
      end
    end
    acc = (p != 0) && !v && m_dead == 0;
    e_l1a = acc;
    if (acc) begin
      e_items = p; e_prio = hp; m_dead = hp ? m_hi : m_lo;
    end else if (m_dead != 0) m_dead--;
    @(negedge clk);
    bx = 0;
    chk({tag, " accept"}, 32'(l1a), 32'(e_l1a));
    chk({tag, " items"}, 32'(items), 32'(e_items));
    chk({tag, " prio"}, 32'(prio), 32'(e_prio));
    @(negedge clk);
    chk("R9 idle accept low", 32'(l1a), 0);
    chk("R8 idle hold items", 32'(items), 32'(e_items));
  endtask

  initial begin
    for (int i = 0; i < NI; i++) begin
      m_en[i] = 0; m_pr[i] = 0; m_ps[i] = 0; m_cnt[i] = 0;
      for (int t = 0; t < NT; t++) begin m_set[i][t] = '0; m_clr[i][t] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset accept", 32'(l1a), 0);
    chk("R1 reset items", 32'(items), 0);
    chk("R1 reset prio", 32'(prio), 0);
    xing('1, 0, "R1 unprogrammed");

    cfg(0, 0, DW'(16'h0001));
    xing(16'h0001, 0, "R4 disabled item");
    chk("R4 no accept", 32'(l1a), 0);
    ctl(0, 1, 0, 1);
    xing(16'h0001, 0, "R2 single object");
    xing(16'h0000, 0, "R2 object clear");
    cfg(1, 0, DW'(16'h0006));
    cfg(1, NT, DW'(16'h0008));
    ctl(1, 1, 1, 0);
    xing(16'h0006, 0, "R2 and pass");
    xing(16'h000e, 0, "R2 not blocks");
    xing(16'h0004, 0, "R2 partial and");
    cfg(2, 1, DW'(16'h0100));
    cfg(2, 3, DW'(16'h0200));
    ctl(2, 1, 0, 3);
    xing(16'h0200, 0, "R3 term3 prescale 1st");
    xing(16'h0100, 0, "R3 term1 prescale 2nd");
    xing(16'h0300, 0, "R5 prescale 3rd");
    chk("R5 third firing passes", 32'(items[2]), 1);
    xing(16'h0001, 1, "R6 veto");
    chk("R6 veto blocks", 32'(l1a), 0);
    cfg(0, 2*NT+1, DW'(16'h0103));
    xing(16'h0001, 0, "R7 low prio accept");
    for (int k = 0; k < 4; k++) xing(16'h0001, 0, "R7 low window");
    xing(16'h0006, 0, "R7 high prio accept");
    for (int k = 0; k < 3; k++) xing(16'h0006, 0, "R7 high window");

    for (int i = 0; i < NI; i++)
      for (int t = 0; t < NT; t++)
        if ($urandom(0) == 0) ;
    void'($urandom(1234));
    for (int i = 0; i < NI; i++) begin
      for (int t = 0; t < NT; t++) begin
        if ($urandom % 2 == 0) begin
          cfg(i, t, DW'($urandom & $urandom & 16'hffff));
          cfg(i, NT+t, DW'($urandom & $urandom & $urandom & 16'hffff));
        end else begin
          cfg(i, t, '0);
          cfg(i, NT+t, '0);
        end
      end
      ctl(i, ($urandom % 5) != 0, $urandom % 2, $urandom % 6);
    end
    cfg(0, 2*NT+1, DW'({8'($urandom % 4), 8'($urandom % 7)}));
    for (int n = 0; n < 500; n++) begin
      if (n % 97 == 50) ctl(n % NI, 1, $urandom % 2, $urandom % 5);
      xing(NO'($urandom | $urandom), ($urandom % 10) == 0, "R6 random crossing");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule